// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the transfer engine of an I2C master. Software presents a command word (start, address, stop and direction flags, a 7-bit target address and a 16-bit byte count) and then streams bytes through an eight-entry FIFO with single-byte host writes or reads. The block drives an abstract byte-level bus port: it asks for a start-plus-address, a byte send, a byte receive or a stop, and the bus side answers each request with a done pulse and, where it applies, a NACK flag or a received byte. Bit timing on SCL and SDA lives below this port.

Two residual counters follow a command. The bus-side counter drops for every byte that crosses the bus. The host-side counter drops for every byte the host moves. Data-request follows direction-specific watermark rules. Command-complete is raised once both counters are exhausted, and the block then closes the bus with a stop if the command asked for one. A command without the stop flag leaves the bus held. The next command can then continue the transfer without a new start.

Top module: `i2cm_xfer_seq`

## Requirements
- R1: A command with start, address and stop flags all clear and a zero length is refused and sets `err_invalid`. `cmd_done` and the counters keep their values.
- R2: A command presented while `cmd_done` is low, or while a stop is in progress, is refused and sets `err_invalid`. It leaves `front_left` and `back_left` untouched.
- R3: An accepted command loads both `front_left` and `back_left` with its length.
- R4: With the start flag set, the block requests bus operation 0 (start) and holds `bus_req` and `bus_op` until `bus_done`. A NACK on the start sets `err_nack`, leaves both busy flags low and sets `cmd_done` again. A positive acknowledge sets `i2c_busy` and `self_busy`, and byte traffic then begins.
- R5: The FIFO holds 8 bytes, and `fifo_count` reports its occupancy. A host write while the FIFO is full, or a host read while it is empty, is dropped. Such an access sets `err_overrun` unless `pacing` is high.
- R6: A host FIFO access while `i2c_busy` is low, or in the direction opposite to the command (a write during a read command, or a read during a write command), sets `err_invalid` and does not change the FIFO.
- R7: Every accepted host FIFO access decrements `back_left`. If `back_left` is already zero, `err_access` is set instead and the byte is still moved.
- R8: Each completed bus byte operation (op 1 send, op 2 receive) decrements `front_left`. A NACK on a sent byte sets `err_nack`, requests a stop (op 3) and then clears both busy flags.
- R9: In a read command, `hi_water` is high when the occupancy is at or above `wm_high`. `data_req` is high when `hi_water` is high with a non-empty FIFO, or when `front_left` is zero, provided the two counters are not both zero.
- R10: In a write command, `lo_water` is high when the occupancy is at or below `wm_low`. `data_req` is high when `back_left` is nonzero and either the free slots are at least `back_left` or `lo_water` is high.
- R11: When both counters are zero, `data_req` is low and `cmd_done` rises. With the stop flag, a stop is requested and both busy flags clear. Without it, the bus stays busy, and a later command without the start flag continues the transfer.
- R12: A host push and a bus-side pop in the same cycle change `fifo_count` by the net amount, so no byte is lost and none is counted twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_start | input | 1 | Command: issue start plus address |
| cmd_addr | input | 1 | Command: address phase flag |
| cmd_stop | input | 1 | Command: finish with stop |
| cmd_read | input | 1 | Command: 1 read, 0 write |
| cmd_dev | input | 7 | Command: target address |
| cmd_len | input | 16 | Command: byte count |
| wm_high | input | 4 | Read-side high watermark |
| wm_low | input | 4 | Write-side low watermark |
| pacing | input | 1 | Suppress overrun errors |
| host_wr | input | 1 | Host FIFO write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host FIFO read strobe |
| host_rdata | output | 8 | Last byte popped by the host |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_dev | output | 7 | Target address for start |
| bus_rnw | output | 1 | Direction for start |
| bus_wdata | output | 8 | Byte to send |
| bus_done | input | 1 | Bus operation finished |
| bus_nack | input | 1 | NACK seen, valid with bus_done |
| bus_rdata | input | 8 | Received byte, valid with bus_done |
| data_req | output | 1 | Host should move data |
| cmd_done | output | 1 | Command complete |
| i2c_busy | output | 1 | Bus held by this master |
| self_busy | output | 1 | Engine busy |
| hi_water | output | 1 | Read occupancy at or above high mark |
| lo_water | output | 1 | Write occupancy at or below low mark |
| err_invalid | output | 1 | Sticky invalid-command error |
| err_nack | output | 1 | Sticky NACK error |
| err_overrun | output | 1 | Sticky overrun error |
| err_access | output | 1 | Sticky host access error |
| fifo_count | output | 8 | FIFO occupancy |
| front_left | output | 16 | Bus-side residual count |
| back_left | output | 16 | Host-side residual count |

## Verification
In a write command, a host push and the pop made by a finishing bus send can land on the same clock edge. The bench provokes this by waiting for the bus to become busy and then writing six bytes on consecutive cycles, so that the first send completes on the edge that takes the fourth push. Just after the sixth push, the occupancy must be exactly five, the bus-side residual five and the host-side residual zero. After the drain, the six bytes seen on the bus must appear in push order.

// File: rtl/i2cm_xfer_seq.sv
module i2cm_xfer_seq #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int LW    = 16,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_start,
  input  logic          cmd_addr,
  input  logic          cmd_stop,
  input  logic          cmd_read,
  input  logic [AW-1:0] cmd_dev,
  input  logic [LW-1:0] cmd_len,
  input  logic [3:0]    wm_high,
  input  logic [3:0]    wm_low,
  input  logic          pacing,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [AW-1:0] bus_dev,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic          bus_nack,
  input  logic [DW-1:0] bus_rdata,
  output logic          data_req,
  output logic          cmd_done,
  output logic          i2c_busy,
  output logic          self_busy,
  output logic          hi_water,
  output logic          lo_water,
  output logic          err_invalid,
  output logic          err_nack,
  output logic          err_overrun,
  output logic          err_access,
  output logic [7:0]    fifo_count,
  output logic [LW-1:0] front_left,
  output logic [LW-1:0] back_left
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_SEND  = 2'd1;
  localparam logic [1:0] OP_RECV  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;

  st_t           st;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [LW-1:0] fe, be;
  logic [AW-1:0] dev_q;
  logic          rnw_q, stop_q, busy_q, sbusy_q, done_q;
  logic          inv_q, nack_q, ovr_q, acc_q;
  logic          req_q;
  logic [1:0]    op_q;
  logic [DW-1:0] rdata_q;

  wire full     = int'(cnt) == DEPTH;
  wire empty    = cnt == '0;
  wire both0    = (fe == '0) && (be == '0);
  wire cmd_null = !cmd_start && !cmd_addr && !cmd_stop && (cmd_len == '0);
  wire cmd_take = cmd_valid && !cmd_null && done_q && (st != S_STOP);
  wire cmd_bad  = cmd_valid && !cmd_take;
  wire op_end   = req_q && bus_done;
  wire byte_end = op_end && (op_q == OP_SEND || op_q == OP_RECV);

  wire wr_dir_ok = busy_q && !rnw_q;
  wire rd_dir_ok = busy_q && rnw_q;
  wire h_wr_ok   = host_wr && wr_dir_ok && !full;
  wire h_rd_ok   = host_rd && rd_dir_ok && !empty;
  wire h_bad     = (host_wr && !wr_dir_ok) || (host_rd && !rd_dir_ok);
  wire h_ovr     = !pacing && ((host_wr && wr_dir_ok && full) ||
                               (host_rd && rd_dir_ok && empty));
  wire h_acc     = h_wr_ok || h_rd_ok;

  wire push = h_wr_ok || (byte_end && op_q == OP_RECV);
  wire pop  = h_rd_ok || (byte_end && op_q == OP_SEND);
  wire [DW-1:0] push_data = h_wr_ok ? host_wdata : bus_rdata;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rdata_q <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (h_rd_ok) rdata_q <= mem[rp];
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fe      <= '0;
      be      <= '0;
      dev_q   <= '0;
      rnw_q   <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
      sbusy_q <= 1'b0;
      done_q  <= 1'b1;
      inv_q   <= 1'b0;
      nack_q  <= 1'b0;
      ovr_q   <= 1'b0;
      acc_q   <= 1'b0;
      req_q   <= 1'b0;
      op_q    <= OP_START;
    end else begin
      if (cmd_bad || h_bad) inv_q <= 1'b1;
      if (h_ovr) ovr_q <= 1'b1;
      if (cmd_take) begin
        fe     <= cmd_len;
        be     <= cmd_len;
        dev_q  <= cmd_dev;
        rnw_q  <= cmd_read;
        stop_q <= cmd_stop;
        if (cmd_start) begin
          st     <= S_START;
          req_q  <= 1'b1;
          op_q   <= OP_START;
          done_q <= 1'b0;
        end else if (busy_q) begin
          done_q <= 1'b0;
        end
      end else begin
        if (h_acc) begin
          if (be == '0) acc_q <= 1'b1;
          else          be    <= be - 1'b1;
        end
        if (byte_end) fe <= fe - 1'b1;
        case (st)
          S_START: if (op_end) begin
            req_q <= 1'b0;
            if (bus_nack) begin
              nack_q <= 1'b1;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              busy_q  <= 1'b1;
              sbusy_q <= 1'b1;
              st      <= S_XFER;
            end
          end
          S_XFER: begin
            done_q <= both0;
            if (op_end) begin
              req_q <= 1'b0;
              if (op_q == OP_SEND && bus_nack) begin
                nack_q <= 1'b1;
                st     <= S_STOP;
              end
            end else if (!req_q) begin
              if (both0) begin
                if (stop_q) st <= S_STOP;
              end else if (fe != '0 && !rnw_q && !empty) begin
                req_q <= 1'b1;
                op_q  <= OP_SEND;
              end else if (fe != '0 && rnw_q && !full) begin
                req_q <= 1'b1;
                op_q  <= OP_RECV;
              end
            end
          end
          S_STOP: begin
            if (op_end) begin
              req_q   <= 1'b0;
              busy_q  <= 1'b0;
              sbusy_q <= 1'b0;
              done_q  <= 1'b1;
              st      <= S_IDLE;
            end else if (!req_q) begin
              req_q <= 1'b1;
              op_q  <= OP_STOP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  wire in_xfer = (st == S_XFER) && busy_q;
  wire hi_w    = in_xfer && rnw_q && (int'(cnt) >= int'(wm_high));
  wire lo_w    = in_xfer && !rnw_q && (int'(cnt) <= int'(wm_low));
  wire rd_req  = (hi_w && !empty) || (fe == '0);
  wire wr_req  = (be != '0) && (((DEPTH - int'(cnt)) >= int'(be)) || lo_w);

  assign data_req    = in_xfer && !both0 && (rnw_q ? rd_req : wr_req);
  assign hi_water    = hi_w;
  assign lo_water    = lo_w;
  assign cmd_done    = done_q;
  assign i2c_busy    = busy_q;
  assign self_busy   = sbusy_q;
  assign err_invalid = inv_q;
  assign err_nack    = nack_q;
  assign err_overrun = ovr_q;
  assign err_access  = acc_q;
  assign fifo_count  = 8'(cnt);
  assign front_left  = fe;
  assign back_left   = be;
  assign host_rdata  = rdata_q;
  assign bus_req     = req_q;
  assign bus_op      = op_q;
  assign bus_dev     = dev_q;
  assign bus_rnw     = rnw_q;
  assign bus_wdata   = mem[rp];

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  assert_pacing_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pacing |=> !$rose(ovr_q));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !bus_done) |=> (req_q && $stable(op_q)));

  assert_back_host_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !host_wr && !host_rd) |=> $stable(be));

  assert_front_bus_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !bus_done) |=> $stable(fe));

  assert_dreq_not_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !done_q);

  assert_stop_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && bus_done && op_q == OP_STOP) |=> (!busy_q && !sbusy_q));

endmodule

// File: tb/i2cm_xfer_seq_tb.sv
module i2cm_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_start = 0, cmd_addr = 0, cmd_stop = 0, cmd_read = 0;
  logic [6:0] cmd_dev = 7'h50;
  logic [15:0] cmd_len = 0;
  logic [3:0] wm_high = 0, wm_low = 0;
  logic pacing = 0, host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic bus_req, bus_rnw, bus_done, bus_nack;
  logic [1:0] bus_op;
  logic [6:0] bus_dev;
  logic [7:0] bus_wdata, bus_rdata;
  logic data_req, cmd_done, i2c_busy, self_busy, hi_water, lo_water;
  logic err_invalid, err_nack, err_overrun, err_access;
  logic [7:0] fifo_count;
  logic [15:0] front_left, back_left;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic hold = 0, nack_start = 0, nack_send = 0;
  logic [7:0] rx_val = 8'h11;
  logic [7:0] sent_buf [64];
  int sent_n;

  always #5 clk = ~clk;

  i2cm_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_addr(cmd_addr), .cmd_stop(cmd_stop), .cmd_read(cmd_read),
    .cmd_dev(cmd_dev), .cmd_len(cmd_len), .wm_high(wm_high), .wm_low(wm_low),
    .pacing(pacing), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .bus_req(bus_req),
    .bus_op(bus_op), .bus_dev(bus_dev), .bus_rnw(bus_rnw),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_nack(bus_nack),
    .bus_rdata(bus_rdata), .data_req(data_req), .cmd_done(cmd_done),
    .i2c_busy(i2c_busy), .self_busy(self_busy), .hi_water(hi_water),
    .lo_water(lo_water), .err_invalid(err_invalid), .err_nack(err_nack),
    .err_overrun(err_overrun), .err_access(err_access),
    .fifo_count(fifo_count), .front_left(front_left), .back_left(back_left)
  );

  // bus responder: answers one cycle after a request; byte ops wait while hold
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_done <= 1'b0;
      bus_nack <= 1'b0;
      bus_rdata <= 8'h00;
      sent_n <= 0;
    end else if (bus_req && !bus_done) begin
      if (bus_op == 2'd0 || bus_op == 2'd3 || !hold) begin
        bus_done <= 1'b1;
        bus_nack <= (bus_op == 2'd0) ? nack_start : (bus_op == 2'd1) ? nack_send : 1'b0;
        bus_rdata <= rx_val;
        if (bus_op == 2'd2) rx_val <= rx_val + 8'd1;
        if (bus_op == 2'd1) begin
          if (sent_n < 64) sent_buf[sent_n] <= bus_wdata;
          sent_n <= sent_n + 1;
        end
      end
    end else begin
      bus_done <= 1'b0;
      bus_nack <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 0; host_wr = 0; host_rd = 0;
    hold = 0; nack_start = 0; nack_send = 0; pacing = 0;
    wm_high = 0; wm_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic st, input logic ad, input logic sp,
                       input logic rd, input int len);
    cmd_start = st; cmd_addr = ad; cmd_stop = sp; cmd_read = rd;
    cmd_len = 16'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    host_wdata = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pop();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 100 && !i2c_busy; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !(cmd_done && !i2c_busy); i++) @(negedge clk);
  endtask

  // {read, length, watermark, expected data_req once settled}
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 8'd1,  4'd0,  1'b1},
    {1'b0, 8'd5,  4'd0,  1'b1},
    {1'b1, 8'd3,  4'd8,  1'b1},
    {1'b1, 8'd12, 4'd9,  1'b0},
    {1'b1, 8'd12, 4'd8,  1'b1},
    {1'b1, 8'd10, 4'd15, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R11 reset cmd_done", int'(cmd_done), 1);
    chk("R4 reset busy", int'({i2c_busy, self_busy}), 0);
    chk("R5 reset count", int'(fifo_count), 0);
    chk("R1 reset errors", int'({err_invalid, err_nack, err_overrun, err_access}), 0);
    chk("R9 reset data_req", int'(data_req), 0);

    for (int v = 0; v < 6; v++) begin
      logic rd; logic [7:0] ln; logic [3:0] wm; logic ex;
      int s0; logic [7:0] r0;
      {rd, ln, wm, ex} = VEC[v];
      wm_high = wm; wm_low = wm;
      s0 = sent_n; r0 = rx_val;
      issue(1, 1, 1, rd, int'(ln));
      wait_busy();
      chk("R4 busy after start", int'({i2c_busy, self_busy}), 3);
      if (rd) begin
        repeat (40) @(negedge clk);
        chk("R9 read data_req", int'(data_req), int'(ex));
        for (int k = 0; k < int'(ln); k++) begin
          for (int t = 0; t < 60 && fifo_count == 0; t++) @(negedge clk);
          pop();
          chk("R9 read byte", int'(host_rdata), int'(8'(r0 + 8'(k))));
        end
      end else begin
        chk("R3 back loaded", int'(back_left), int'(ln));
        chk("R10 write data_req", int'(data_req), int'(ex));
        for (int k = 0; k < int'(ln); k++) push(8'hA0 + 8'(k));
        wait_idle();
        for (int k = 0; k < int'(ln); k++)
          chk("R8 sent byte", int'(sent_buf[s0 + k]), int'(8'hA0 + 8'(k)));
      end
      wait_idle();
      chk("R11 idle after stop", int'({cmd_done, i2c_busy}), 2);
      chk("R11 counters zero", int'(front_left) + int'(back_left), 0);
      chk("R7 no errors", int'({err_invalid, err_nack, err_overrun, err_access}), 0);
    end

    // R12: push and bus pop on one edge
    do_reset();
    issue(1, 1, 1, 0, 6);
    wait_busy();
    for (int k = 0; k < 6; k++) push(8'h30 + 8'(k));
    chk("R12 count after overlap", int'(fifo_count), 5);
    chk("R12 front after overlap", int'(front_left), 5);
    chk("R7 back after six", int'(back_left), 0);
    wait_idle();
    chk("R12 sent total", sent_n, 6);
    for (int k = 0; k < 6; k++)
      chk("R12 sent order", int'(sent_buf[k]), int'(8'h30 + 8'(k)));
    chk("R12 no overrun", int'(err_overrun), 0);

    // R10 low watermark with stalled bus, then R5 overrun
    do_reset();
    hold = 1; wm_low = 4'd2;
    issue(1, 1, 1, 0, 12);
    wait_busy();
    for (int k = 0; k < 5; k++) push(8'(k));
    chk("R10 count 5", int'(fifo_count), 5);
    chk("R10 lo_water off", int'(lo_water), 0);
    chk("R10 data_req off", int'(data_req), 0);
    chk("R7 back 7", int'(back_left), 7);
    wm_low = 4'd5;
    @(negedge clk);
    chk("R10 lo_water on", int'(lo_water), 1);
    chk("R10 data_req on", int'(data_req), 1);
    for (int k = 0; k < 3; k++) push(8'(k));
    chk("R10 full data_req", int'(data_req), 0);
    push(8'hEE);
    chk("R5 overrun set", int'(err_overrun), 1);
    chk("R5 dropped count", int'(fifo_count), 8);
    chk("R5 dropped back", int'(back_left), 4);

    // R5 empty read, with and without pacing
    do_reset();
    hold = 1; pacing = 1;
    issue(1, 1, 1, 1, 4);
    wait_busy();
    pop();
    chk("R5 pacing no overrun", int'(err_overrun), 0);
    chk("R5 pacing dropped", int'(back_left), 4);
    do_reset();
    hold = 1;
    issue(1, 1, 1, 1, 4);
    wait_busy();
    pop();
    chk("R5 empty overrun", int'(err_overrun), 1);
    chk("R5 empty dropped", int'(back_left), 4);

    // R7 access error
    do_reset();
    hold = 1;
    issue(1, 1, 1, 0, 2);
    wait_busy();
    for (int k = 0; k < 3; k++) push(8'(k));
    chk("R7 access error", int'(err_access), 1);
    chk("R7 byte kept", int'(fifo_count), 3);

    // R2 command while in progress
    do_reset();
    hold = 1;
    issue(1, 1, 1, 0, 4);
    wait_busy();
    issue(1, 1, 1, 0, 9);
    chk("R2 invalid", int'(err_invalid), 1);
    chk("R2 front kept", int'(front_left), 4);
    chk("R2 back kept", int'(back_left), 4);

    // R1 null command
    do_reset();
    issue(0, 0, 0, 0, 0);
    chk("R1 invalid", int'(err_invalid), 1);
    chk("R1 done kept", int'(cmd_done), 1);

    // R6 idle and wrong-direction access
    do_reset();
    push(8'h5A);
    chk("R6 idle write invalid", int'(err_invalid), 1);
    chk("R6 idle count", int'(fifo_count), 0);
    do_reset();
    hold = 1;
    issue(1, 1, 1, 1, 2);
    wait_busy();
    push(8'h5A);
    chk("R6 direction invalid", int'(err_invalid), 1);
    chk("R6 direction count", int'(fifo_count), 0);

    // R4 start NACK
    do_reset();
    nack_start = 1;
    issue(1, 1, 1, 0, 2);
    repeat (6) @(negedge clk);
    chk("R4 nack err", int'(err_nack), 1);
    chk("R4 nack not busy", int'({i2c_busy, self_busy}), 0);
    chk("R4 nack done", int'(cmd_done), 1);

    // R8 NACK on sent byte
    do_reset();
    nack_send = 1;
    issue(1, 1, 1, 0, 3);
    wait_busy();
    push(8'h77);
    wait_idle();
    chk("R8 send nack err", int'(err_nack), 1);
    chk("R8 bus released", int'({i2c_busy, self_busy}), 0);
    chk("R8 front after one", int'(front_left), 2);

    // R11 held bus and continuation
    do_reset();
    issue(1, 1, 0, 0, 1);
    wait_busy();
    push(8'h21);
    for (int i = 0; i < 50 && !cmd_done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11 held busy", int'({cmd_done, i2c_busy}), 3);
    issue(0, 0, 1, 0, 1);
    chk("R3 continue load", int'(back_left), 1);
    push(8'h22);
    wait_idle();
    chk("R11 continue stop", int'({cmd_done, i2c_busy}), 2);
    chk("R11 continue sent", sent_n, 2);
    chk("R11 continue byte", int'(sent_buf[1]), 8'h22);

    // R11 zero-length command
    do_reset();
    issue(1, 1, 1, 0, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R11 zero length done", int'({cmd_done, i2c_busy}), 2);
    chk("R11 zero length clean", int'({err_invalid, err_nack}), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule